// File: doc/BRIEF.md
# Slave Register Access Cycle Controller

This block lets an external host read and write a device's internal registers over a strobe-based bus. The host selects the device with an active-low chip select. It marks each access with an active-low address strobe, a read/write line and a 6-bit register number. The block answers with an active-low slave acknowledge when the access begins. It later drives an active-low two-bit size acknowledge, which tells the host the access is complete. For reads it drives register data with a separate output enable, so that a tri-state buffer can sit at the chip level. For writes it latches the low 16 data lines into the selected register.

Chip select is asynchronous to the block's clock and goes through a two-stage synchronizer. The strobe, the read/write line, the address and the write data are sampled directly on each rising clock edge. The device may be busy as a bus master when it is selected. In that case the block raises a yield request. It waits for the master engine to report the end of its current cycle before it acknowledges, so the acknowledge moves later by every wait state of that master cycle. A host may hold chip select low and use the strobe alone to mark out a series of accesses. An array of 64 registers, each 16 bits wide, stands in for the device's register file.

Top module: `reg_slave_ctrl`

## Requirements
- R1: While reset is applied and after it is released, slvAckN is 1, sizeAckN is 2'b11, rdDataOe is 0 and busYield is 0, and every register reads back as 0.
- R2: In the non-master case, with strobeN low, slvAckN first goes low after the 4th rising edge that samples csN low. That is two synchronizer stages, one capture edge and one acknowledge edge. It is still high after the 3rd such edge.
- R3: No cycle starts from strobeN low while csN is high, or from csN low while strobeN is high. slvAckN stays 1 in both cases.
- R4: rdWr = 1 selects a read. rdData and rdDataOe = 1 change on the same edge that drives slvAckN low, and rdData holds the addressed register.
- R5: Both bits of sizeAckN go low together exactly 2 clocks after slvAckN goes low, for reads and for writes. sizeAckN is only ever 2'b11 or 2'b00.
- R6: After the first rising edge that samples strobeN high during a cycle, slvAckN, sizeAckN and rdDataOe are all inactive.
- R7: If csN rises while strobeN stays low, the outputs become inactive after the 3rd rising edge that samples csN high.
- R8: While csN is held low, each new low strobeN starts a fresh cycle. slvAckN goes low after the 2nd rising edge that samples strobeN low, and it returns high between strobes.
- R9: If masterOwn is 1 at the capture edge, busYield is 1 from that edge on and slvAckN stays high. When masterCycEnd is sampled high, busYield drops at that edge and slvAckN goes low one edge later. The acknowledge therefore moves later by one clock per wait state.
- R10: rdWr = 0 selects a write. The 6-bit regAddr picks one of 64 registers, the addresses 0 and 63 included. dataIn[15:0] is stored at the edge that drives sizeAckN low, and no other register changes.
- R11: If strobeN goes high while the block waits for the master, busYield drops after that edge and no acknowledge follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Asynchronous active-low chip select |
| strobeN | input | 1 | Active-low address strobe |
| rdWr | input | 1 | 1 = read, 0 = write |
| regAddr | input | 6 | Register number |
| dataIn | input | 16 | Write data, low 16 data lines |
| masterOwn | input | 1 | Device currently owns the bus as master |
| masterCycEnd | input | 1 | Master engine finished its cycle and released the bus |
| slvAckN | output | 1 | Active-low slave acknowledge, cycle started |
| sizeAckN | output | 2 | Active-low size acknowledge pair, cycle terminated |
| rdData | output | 16 | Read data |
| rdDataOe | output | 1 | Output enable for rdData |
| busYield | output | 1 | Request to the master engine to give up the bus |

## Verification
The main cycle is tried with four chip-select and strobe patterns: a fresh chip select with the strobe already low, chip select held across several strobes, chip select rising before the strobe, and the strobe rising before chip select. These separate the synchronizer latency from the direct strobe latency, and they show that each release path works on its own. The master case is run with zero and with several wait states, and once with the strobe withdrawn while the block is waiting. This confirms that the acknowledge follows the end of the master cycle and not a fixed count. Writes to neighbouring and boundary addresses, each read back, show that the address decode and the write timing are correct.

// File: rtl/reg_slave_pkg.sv
package reg_slave_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ARM,
    ST_ACK,
    ST_TERM
  } slvStateT;

  typedef struct packed {
    logic latch;    // capture address and direction
    logic drive;    // start driving read data
    logic write;    // store write data
    logic release_; // drop all driven outputs
  } ctlStrobeT;

endpackage

// File: rtl/reg_slave_fsm.sv
module reg_slave_fsm
  import reg_slave_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACK_TO_TERM = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      strobeN,
  input  logic      masterOwn,
  input  logic      masterCycEnd,
  output logic      slvAckN,
  output logic [1:0] sizeAckN,
  output logic      busYield,
  output ctlStrobeT ctl
);

  localparam int CNT_W = (ACK_TO_TERM > 1) ? $clog2(ACK_TO_TERM) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_TO_TERM - 1);

  logic [SYNC_STAGES-1:0] csPipe;
  logic csSync;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) csPipe <= '0;
        else       csPipe <= ~csN;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) csPipe <= '0;
        else       csPipe <= {csPipe[SYNC_STAGES-2:0], ~csN};
      end
    end
  endgenerate

  assign csSync = csPipe[SYNC_STAGES-1];

  slvStateT state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic slvAckNext, yieldNext;
  logic [1:0] sizeNext;
  logic endReq;

  assign endReq = strobeN || !csSync;

  always_comb begin
    stateNext  = state;
    cntNext    = cnt;
    slvAckNext = slvAckN;
    sizeNext   = sizeAckN;
    yieldNext  = busYield;
    ctl        = '0;
    unique case (state)
      ST_IDLE: begin
        if (csSync && !strobeN) begin
          ctl.latch = 1'b1;
          if (masterOwn) begin
            stateNext = ST_WAIT;
            yieldNext = 1'b1;
          end else begin
            stateNext = ST_ARM;
          end
        end
      end
      ST_WAIT: begin
        if (endReq) begin
          stateNext = ST_IDLE;
          yieldNext = 1'b0;
          ctl.release_ = 1'b1;
        end else if (masterCycEnd) begin
          stateNext = ST_ARM;
          yieldNext = 1'b0;
        end
      end
      ST_ARM: begin
        if (endReq) begin
          stateNext = ST_IDLE;
          ctl.release_ = 1'b1;
        end else begin
          stateNext  = ST_ACK;
          slvAckNext = 1'b0;
          cntNext    = '0;
          ctl.drive  = 1'b1;
        end
      end
      ST_ACK: begin
        if (endReq) begin
          stateNext  = ST_IDLE;
          slvAckNext = 1'b1;
          ctl.release_ = 1'b1;
        end else if (cnt == CNT_LAST) begin
          stateNext = ST_TERM;
          sizeNext  = 2'b00;
          ctl.write = 1'b1;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_TERM: begin
        if (endReq) begin
          stateNext  = ST_IDLE;
          slvAckNext = 1'b1;
          sizeNext   = 2'b11;
          ctl.release_ = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      slvAckN  <= 1'b1;
      sizeAckN <= 2'b11;
      busYield <= 1'b0;
    end else begin
      state    <= stateNext;
      cnt      <= cntNext;
      slvAckN  <= slvAckNext;
      sizeAckN <= sizeNext;
      busYield <= yieldNext;
    end
  end

endmodule

// File: rtl/reg_slave_dp.sv
module reg_slave_dp
  import reg_slave_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         ctl,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              rdWr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDataOe
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic              isReadQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      isReadQ <= 1'b0;
    end else if (ctl.latch) begin
      addrQ   <= regAddr;
      isReadQ <= rdWr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      rdDataOe <= 1'b0;
    end else if (ctl.release_) begin
      rdData   <= '0;
      rdDataOe <= 1'b0;
    end else if (ctl.drive && isReadQ) begin
      rdData   <= regs[addrQ];
      rdDataOe <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (ctl.write && !isReadQ) begin
      regs[addrQ] <= dataIn;
    end
  end

endmodule

// File: rtl/reg_slave_ctrl.sv
module reg_slave_ctrl
  import reg_slave_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ACK_TO_TERM = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              strobeN,
  input  logic              rdWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              masterOwn,
  input  logic              masterCycEnd,
  output logic              slvAckN,
  output logic [1:0]        sizeAckN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDataOe,
  output logic              busYield
);

  ctlStrobeT ctl;

  reg_slave_fsm #(
    .SYNC_STAGES(SYNC_STAGES),
    .ACK_TO_TERM(ACK_TO_TERM)
  ) i_fsm (
    .clk(clk), .rstN(rstN), .csN(csN), .strobeN(strobeN),
    .masterOwn(masterOwn), .masterCycEnd(masterCycEnd),
    .slvAckN(slvAckN), .sizeAckN(sizeAckN), .busYield(busYield), .ctl(ctl)
  );

  reg_slave_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .regAddr(regAddr), .rdWr(rdWr),
    .dataIn(dataIn), .rdData(rdData), .rdDataOe(rdDataOe)
  );

endmodule

// File: rtl/reg_slave_chk.sv
module reg_slave_chk (
  input logic       clk,
  input logic       rstN,
  input logic       strobeN,
  input logic       slvAckN,
  input logic [1:0] sizeAckN,
  input logic       rdDataOe,
  input logic       busYield
);

  AST_SIZE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (sizeAckN == 2'b00) || (sizeAckN == 2'b11)); // R5

  AST_SIZE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (sizeAckN == 2'b00) |-> !slvAckN); // R5

  AST_SIZE_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sizeAckN[0]) |-> ($past(!slvAckN, 2) && $past(slvAckN, 3))); // R5

  AST_OE_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    rdDataOe |-> !slvAckN); // R4

  AST_STROBE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (!slvAckN && strobeN) |=> (slvAckN && sizeAckN == 2'b11 && !rdDataOe)); // R6

  AST_YIELD_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    busYield |-> slvAckN); // R9

endmodule

bind reg_slave_ctrl reg_slave_chk i_chk (
  .clk(clk), .rstN(rstN), .strobeN(strobeN), .slvAckN(slvAckN),
  .sizeAckN(sizeAckN), .rdDataOe(rdDataOe), .busYield(busYield)
);

// File: tb/test_reg_slave_ctrl.sv
`timescale 1ns/1ps
module test_reg_slave_ctrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, strobeN = 1'b1, rdWr = 1'b1;
  logic [5:0] regAddr = '0;
  logic [15:0] dataIn = '0;
  logic masterOwn = 1'b0, masterCycEnd = 1'b0;
  logic slvAckN, rdDataOe, busYield;
  logic [1:0] sizeAckN;
  logic [15:0] rdData;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  reg_slave_ctrl i_reg_slave_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .strobeN(strobeN), .rdWr(rdWr),
    .regAddr(regAddr), .dataIn(dataIn), .masterOwn(masterOwn),
    .masterCycEnd(masterCycEnd), .slvAckN(slvAckN), .sizeAckN(sizeAckN),
    .rdData(rdData), .rdDataOe(rdDataOe), .busYield(busYield)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic stepClk(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleOut(string req);
    chk(req, "slvAckN", slvAckN, 1);
    chk(req, "sizeAckN", sizeAckN, 2'b11);
    chk(req, "rdDataOe", rdDataOe, 0);
  endtask

  task automatic endCycle();
    strobeN = 1'b1;
    stepClk(1);
    idleOut("R6");
    csN = 1'b1;
    stepClk(3);
  endtask

  // R2 R5 R10: fresh chip select, write
  task automatic writeCyc(logic [5:0] a, logic [15:0] d);
    rdWr = 1'b0; regAddr = a; dataIn = d; csN = 1'b0; strobeN = 1'b0;
    stepClk(3);
    chk("R2", "ack before 4th edge", slvAckN, 1);
    stepClk(1);
    chk("R2", "ack at 4th edge", slvAckN, 0);
    chk("R4", "oe on write", rdDataOe, 0);
    stepClk(1);
    chk("R5", "size one clock after ack", sizeAckN, 2'b11);
    stepClk(1);
    chk("R5", "size two clocks after ack", sizeAckN, 2'b00);
    endCycle();
  endtask

  // R4: fresh chip select, read
  task automatic readCyc(logic [5:0] a, logic [15:0] exp, string req);
    rdWr = 1'b1; regAddr = a; csN = 1'b0; strobeN = 1'b0;
    stepClk(3);
    chk("R4", "oe before ack", rdDataOe, 0);
    stepClk(1);
    chk("R4", "ack", slvAckN, 0);
    chk("R4", "oe with ack", rdDataOe, 1);
    chk(req, "read data", rdData, exp);
    stepClk(2);
    chk("R5", "size on read", sizeAckN, 2'b00);
    endCycle();
  endtask

  task automatic testIgnore();
    strobeN = 1'b0; csN = 1'b1;
    stepClk(6);
    chk("R3", "strobe alone", slvAckN, 1);
    strobeN = 1'b1; csN = 1'b0;
    stepClk(6);
    chk("R3", "cs alone", slvAckN, 1);
    csN = 1'b1;
    stepClk(3);
  endtask

  task automatic testCsRelease();
    rdWr = 1'b1; regAddr = 6'd5; csN = 1'b0; strobeN = 1'b0;
    stepClk(6);
    chk("R7", "size before cs rise", sizeAckN, 2'b00);
    csN = 1'b1;
    stepClk(2);
    chk("R7", "ack 2 edges after cs rise", slvAckN, 0);
    stepClk(1);
    idleOut("R7");
    strobeN = 1'b1;
    stepClk(3);
    chk("R7", "no restart", slvAckN, 1);
  endtask

  task automatic testMulti();
    csN = 1'b0; strobeN = 1'b1;
    stepClk(3);
    for (int k = 0; k < 2; k++) begin
      rdWr = 1'b1; regAddr = (k == 0) ? 6'd5 : 6'd6; strobeN = 1'b0;
      stepClk(1);
      chk("R8", "ack after 1 edge", slvAckN, 1);
      stepClk(1);
      chk("R8", "ack after 2 edges", slvAckN, 0);
      chk("R8", "data", rdData, (k == 0) ? 32'h1234 : 32'hbeef);
      stepClk(2);
      chk("R8", "size", sizeAckN, 2'b00);
      strobeN = 1'b1;
      stepClk(1);
      chk("R8", "ack high between strobes", slvAckN, 1);
    end
    csN = 1'b1;
    stepClk(3);
  endtask

  task automatic testMaster(int waits);
    masterOwn = 1'b1; rdWr = 1'b1; regAddr = 6'd6; csN = 1'b0; strobeN = 1'b0;
    stepClk(3);
    chk("R9", "yield at capture", busYield, 1);
    chk("R9", "no ack while master", slvAckN, 1);
    stepClk(waits);
    chk("R9", "still waiting", slvAckN, 1);
    masterCycEnd = 1'b1;
    stepClk(1);
    masterCycEnd = 1'b0; masterOwn = 1'b0;
    chk("R9", "yield dropped", busYield, 0);
    chk("R9", "ack one edge later", slvAckN, 1);
    stepClk(1);
    chk("R9", "ack", slvAckN, 0);
    chk("R9", "data", rdData, 32'hbeef);
    endCycle();
  endtask

  task automatic testAbort();
    masterOwn = 1'b1; rdWr = 1'b1; regAddr = 6'd5; csN = 1'b0; strobeN = 1'b0;
    stepClk(4);
    chk("R11", "waiting", busYield, 1);
    strobeN = 1'b1;
    stepClk(1);
    chk("R11", "yield dropped", busYield, 0);
    masterCycEnd = 1'b1;
    stepClk(1);
    masterCycEnd = 1'b0; masterOwn = 1'b0;
    stepClk(3);
    chk("R11", "no ack", slvAckN, 1);
    csN = 1'b1;
    stepClk(3);
  endtask

  initial begin
    #2_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    idleOut("R1");
    chk("R1", "busYield", busYield, 0);
    stepClk(2);
    rstN = 1'b1;
    stepClk(1);
    idleOut("R1");
    readCyc(6'd63, 16'h0000, "R1");
    writeCyc(6'd5, 16'h1234);
    writeCyc(6'd6, 16'hbeef);
    writeCyc(6'd0, 16'h00a5);
    readCyc(6'd5, 16'h1234, "R10");
    readCyc(6'd6, 16'hbeef, "R10");
    readCyc(6'd0, 16'h00a5, "R10");
    readCyc(6'd63, 16'h0000, "R10");
    testIgnore();
    testCsRelease();
    testMulti();
    testMaster(0);
    testMaster(3);
    testAbort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule